// File: doc/BRIEF.md
# Conditional Trap Detector

This block watches the instruction stream of a processor core and recognises the two conditional-trap instruction forms. For each candidate word it takes the value of one source register and either a second source register or a sign-extended 16-bit constant, evaluates five relations between them (signed less, signed greater, equal, unsigned less, unsigned greater), and requests a trap when any relation enabled by the instruction's 5-bit condition mask holds. The register file lives outside the block. The block drives the two source register indices straight from the instruction word, and the register file returns the operand values in the same cycle.

One cycle after a valid strobe, the block gives a one-cycle decoded pulse for any recognised trap form and a one-cycle trap pulse when the condition holds. It also holds the instruction address of the most recent trapping instruction. The word 0x7FE00008 compares register 0 with itself under an all-ones mask. Equality always holds for it, so it traps on every execution and can serve as the software breakpoint. Exception vectoring and pipeline flush belong to the surrounding core.

Top module: `trap_unit`

## Requirements
- R1: While rst_n is low at a clock edge, insn_decoded, trap_req and trap_pc are cleared to zero on that edge.
- R2: A word with bits [31:26] = 31 and bits [10:1] = 4 is the register form. With insn_valid high, insn_decoded is high in the next cycle. Bit 0 is ignored.
- R3: A word with bits [31:26] = 3 is the immediate form. With insn_valid high, insn_decoded is high in the next cycle.
- R4: Any other word raises neither insn_decoded nor trap_req, whatever its operands are.
- R5: The condition mask is bits [25:21]. Bit 25 enables signed a<b, bit 24 signed a>b, bit 23 a==b, bit 22 unsigned a<b, and bit 21 unsigned a>b. trap_req is the OR of the enabled relations.
- R6: Signed and unsigned relations are evaluated separately. For example, a=0xFFFFFFFF, b=1 is signed-less and unsigned-greater.
- R7: A zero condition mask never raises trap_req.
- R8: The word 0x7FE00008, when valid, always raises trap_req, whatever value register 0 holds.
- R9: insn_decoded and trap_req are high for exactly the one cycle after a valid strobe, and low after a cycle with insn_valid low.
- R10: trap_pc takes insn_pc of the instruction that raises trap_req, in the same cycle as the pulse, and holds it until the next trap.
- R11: rs_a_idx is bits [20:16] and rs_b_idx is bits [15:11] of insn_word, combinationally.
- R12: In the immediate form, b is bits [15:0] sign-extended to the operand width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | insn_word is an instruction to evaluate this cycle |
| insn_word | input | 32 | Instruction word |
| insn_pc | input | ADDR_W | Address of insn_word |
| src_a | input | XLEN | Value of register rs_a_idx |
| src_b | input | XLEN | Value of register rs_b_idx |
| rs_a_idx | output | 5 | First source register index |
| rs_b_idx | output | 5 | Second source register index |
| insn_decoded | output | 1 | Pulse: the previous valid word was a trap form |
| trap_req | output | 1 | Pulse: the previous valid word's condition held |
| trap_pc | output | ADDR_W | Address of the most recent trapping instruction |

## Verification
The bench builds the block with XLEN = 32 and ADDR_W = 32. These widths put the operand sign bit at the same position as bit 31 of the sign-extended immediate, so negative constants exercise the signed and unsigned relations at full width. A full-width address also lets the held trap address be told apart from the addresses of later non-trapping words. Operands are chosen at the sign boundary, such as 0xFFFFFFFF against 1 and 0x80000000 against 0x7FFFFFFF, where the signed and unsigned answers disagree.

// File: rtl/trap_pkg.sv
// Package: shared encodings and types of the conditional trap detector.
// Assumes a 32-bit instruction word with the primary opcode in bits [31:26].
package trap_pkg;
    localparam int INSN_W = 32;
    localparam int IDX_W  = 5;
    localparam int IMM_W  = 16;
    localparam logic [5:0] OPC_TRAP_REG = 6'd31;
    localparam logic [5:0] OPC_TRAP_IMM = 6'd3;
    localparam logic [9:0] XOP_TRAP     = 10'd4;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_REG  = 2'd1,
        FORM_IMM  = 2'd2
    } trap_form_e;

    // Field order matches mask bits [25:21] from most to least significant
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_vec_t;

    typedef struct packed {
        trap_form_e        form;
        rel_vec_t          mask;
        logic [IDX_W-1:0]  ra;
        logic [IDX_W-1:0]  rb;
        logic [IMM_W-1:0]  imm;
    } trap_fields_t;
endpackage

// File: rtl/trap_decode.sv
// Module: trap_decode
// Splits an instruction word into trap form, condition mask, register
// indices and immediate. Purely combinational. Assumes the reserved low
// bit of the register form carries no meaning.
module trap_decode
    import trap_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output trap_fields_t      fields
);
    logic [5:0] opc;
    logic [9:0] xop;

    // Extract the fixed opcode fields
    always_comb begin
        opc = insn[31:26];
        xop = insn[10:1];
    end

    // Classify the word and slice the operand fields
    always_comb begin
        fields.mask = rel_vec_t'(insn[25:21]);
        fields.ra   = insn[20:16];
        fields.rb   = insn[15:11];
        fields.imm  = insn[IMM_W-1:0];
        if (opc == OPC_TRAP_REG && xop == XOP_TRAP)
            fields.form = FORM_REG;
        else if (opc == OPC_TRAP_IMM)
            fields.form = FORM_IMM;
        else
            fields.form = FORM_NONE;
    end
endmodule

// File: rtl/trap_opsel.sv
// Module: trap_opsel
// Picks the second comparison operand: the register value for the
// register form, the sign-extended immediate otherwise. Assumes
// XLEN >= IMM_W.
module trap_opsel
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  reg_val,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    output logic [XLEN-1:0]  opnd
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    // Replicate the immediate sign bit over the upper operand bits
    generate
        if (EXT_W > 0) begin : g_ext
            always_comb imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_noext
            always_comb imm_ext = imm[XLEN-1:0];
        end
    endgenerate

    // Select between register operand and extended constant
    always_comb opnd = use_imm ? imm_ext : reg_val;
endmodule

// File: rtl/trap_compare.sv
// Module: trap_compare
// Computes the five relations between a and b from a single shared
// subtractor. Combinational. Assumes two's-complement operands.
module trap_compare
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output rel_vec_t        rel
);
    localparam int MSB = XLEN - 1;

    logic [XLEN:0] diff;
    logic          borrow;
    logic          same;
    logic          s_less;

    // Shared subtract: the borrow out is the unsigned less-than
    always_comb begin
        diff   = {1'b0, a} - {1'b0, b};
        borrow = diff[XLEN];
        same   = (a == b);
    end

    // Signed less-than: differing signs decide, else the borrow decides
    always_comb s_less = (a[MSB] != b[MSB]) ? a[MSB] : borrow;

    // Assemble the relation vector
    always_comb begin
        rel.slt = s_less;
        rel.sgt = !s_less && !same;
        rel.eq  = same;
        rel.ult = borrow;
        rel.ugt = !borrow && !same;
    end
endmodule

// File: rtl/trap_unit.sv
// Module: trap_unit (top)
// Conditional trap detector. Decodes the register and immediate trap
// forms, compares operands supplied by an external register file in the
// same cycle, and registers a one-cycle decoded pulse, a one-cycle trap
// pulse and the address of the most recent trapping instruction.
// Assumes src_a/src_b are valid in the cycle the indices are driven.
module trap_unit
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn_word,
    input  logic [ADDR_W-1:0] insn_pc,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    output logic [IDX_W-1:0]  rs_a_idx,
    output logic [IDX_W-1:0]  rs_b_idx,
    output logic              insn_decoded,
    output logic              trap_req,
    output logic [ADDR_W-1:0] trap_pc
);
    trap_fields_t    fld;
    logic [XLEN-1:0] opnd_b;
    rel_vec_t        rel;
    logic            is_trap_form;
    logic            cond_hit;
    logic            dec_q;
    logic            trap_q;
    logic [ADDR_W-1:0] pc_q;
    logic            past_ok;

    trap_decode u_decode (
        .insn   (insn_word),
        .fields (fld)
    );

    trap_opsel #(.XLEN(XLEN)) u_opsel (
        .reg_val (src_b),
        .imm     (fld.imm),
        .use_imm (fld.form == FORM_IMM),
        .opnd    (opnd_b)
    );

    trap_compare #(.XLEN(XLEN)) u_compare (
        .a   (src_a),
        .b   (opnd_b),
        .rel (rel)
    );

    // Register indices go straight to the external register file
    always_comb begin
        rs_a_idx = fld.ra;
        rs_b_idx = fld.rb;
    end

    // Mask-selected OR of the relations, gated by a recognised form
    always_comb begin
        is_trap_form = (fld.form != FORM_NONE);
        cond_hit     = is_trap_form && ((fld.mask & rel) != '0);
    end

    // Output pulses, valid only for the cycle after a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q  <= 1'b0;
            trap_q <= 1'b0;
        end else begin
            dec_q  <= insn_valid && is_trap_form;
            trap_q <= insn_valid && cond_hit;
        end
    end

    // Capture the address of a trapping instruction
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (insn_valid && cond_hit)
            pc_q <= insn_pc;
    end

    // Marks cycles whose $past lies after reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        insn_decoded = dec_q;
        trap_req     = trap_q;
        trap_pc      = pc_q;
    end

    // R4
    trap_needs_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> insn_decoded);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(insn_valid)) |-> (!insn_decoded && !trap_req));

    // R8
    breakpoint_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word == 32'h7FE0_0008) |=> trap_req);

    // R7
    zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word[25:21] == 5'd0) |=> !trap_req);

    // R10
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !trap_req) |-> $stable(trap_pc));

    // R6
    rel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rel.slt, rel.sgt, rel.eq}) == 1 &&
        $countones({rel.ult, rel.ugt, rel.eq}) == 1);
endmodule

// File: tb/trap_unit_bench.sv
// Bench for trap_unit: a behavioural reference model predicts the
// registered outputs each cycle; outputs are compared at the falling edge.
module trap_unit_bench;
    localparam int XLEN   = 32;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              insn_valid = 1'b0;
    logic [31:0]       insn_word = 32'h0;
    logic [ADDR_W-1:0] insn_pc = '0;
    logic [XLEN-1:0]   src_a = '0;
    logic [XLEN-1:0]   src_b = '0;
    logic [4:0]        rs_a_idx, rs_b_idx;
    logic              insn_decoded, trap_req;
    logic [ADDR_W-1:0] trap_pc;

    int n_cmp = 0;
    int n_bad = 0;

    bit              exp_dec = 0;
    bit              exp_trap = 0;
    bit [ADDR_W-1:0] exp_pc = '0;

    always #2 clk = ~clk;

    trap_unit #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_trap_unit (
        .clk, .rst_n, .insn_valid, .insn_word, .insn_pc, .src_a, .src_b,
        .rs_a_idx, .rs_b_idx, .insn_decoded, .trap_req, .trap_pc
    );

    task automatic check(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural model of one evaluated word
    task automatic model(input bit v, input bit [31:0] w, input bit [ADDR_W-1:0] pc,
                         input bit [31:0] a, input bit [31:0] b,
                         output bit dec, output bit trp);
        int unsigned op = w >> 26;
        int unsigned xo = (w >> 1) & 10'h3FF;
        int unsigned m  = (w >> 21) & 5'h1F;
        bit [31:0] bb;
        longint sa, sb;
        bit reg_form = (op == 31) && (xo == 4);
        bit imm_form = (op == 3);
        dec = v && (reg_form || imm_form);
        if (imm_form) bb = {{16{w[15]}}, w[15:0]};
        else          bb = b;
        sa = longint'($signed(a));
        sb = longint'($signed(bb));
        trp = 0;
        if (m[4] && sa < sb) trp = 1;
        if (m[3] && sa > sb) trp = 1;
        if (m[2] && a == bb) trp = 1;
        if (m[1] && a < bb)  trp = 1;
        if (m[0] && a > bb)  trp = 1;
        trp = trp && dec;
    endtask

    task automatic step(string req, bit v, bit [31:0] w, bit [ADDR_W-1:0] pc,
                        bit [31:0] a, bit [31:0] b);
        bit d, t;
        @(negedge clk);
        insn_valid = v; insn_word = w; insn_pc = pc; src_a = a; src_b = b;
        #1;
        check("R11 ra", rs_a_idx, (w >> 16) & 5'h1F);
        check("R11 rb", rs_b_idx, (w >> 11) & 5'h1F);
        model(v, w, pc, a, b, d, t);
        @(posedge clk);
        exp_dec = d; exp_trap = t;
        if (t) exp_pc = pc;
        @(negedge clk);
        check({req, " decoded"}, insn_decoded, exp_dec);
        check({req, " trap"}, trap_req, exp_trap);
        check({req, " pc"}, trap_pc, exp_pc);
        insn_valid = 0;
    endtask

    function automatic bit [31:0] rr(int m, int ra, int rb);
        return (32'd31 << 26) | (m << 21) | (ra << 16) | (rb << 11) | (32'd4 << 1);
    endfunction

    function automatic bit [31:0] ri(int m, int ra, bit [15:0] imm);
        return (32'd3 << 26) | (m << 21) | (ra << 16) | imm;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears outputs
        check("R1 decoded", insn_decoded, 0);
        check("R1 trap", trap_req, 0);
        check("R1 pc", trap_pc, 0);
        rst_n = 1;

        // R8: breakpoint word traps for any register value
        step("R8", 1, 32'h7FE0_0008, 32'h1000, 32'h0, 32'h0);
        check("R8 explicit", trap_req, 1);
        step("R8", 1, 32'h7FE0_0008, 32'h1004, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        step("R8", 1, 32'h7FE0_0008, 32'h1008, 32'h8000_0000, 32'h8000_0000);

        // R9: no strobe, no pulse; pulse lasts one cycle
        step("R9", 0, 32'h7FE0_0008, 32'h2000, 32'h0, 32'h0);
        check("R9 explicit", trap_req, 0);
        // R10: trap_pc still holds 0x1008
        check("R10 hold", trap_pc, 32'h1008);

        // R5/R6: each mask bit alone, a=-1 b=1 (slt, ugt true)
        for (int i = 0; i < 5; i++)
            step("R5", 1, rr(1 << i, 3, 4), 32'h3000 + i * 4, 32'hFFFF_FFFF, 32'h1);
        step("R6", 1, rr(5'b10000, 3, 4), 32'h3100, 32'hFFFF_FFFF, 32'h1);
        check("R6 slt", trap_req, 1);
        step("R6", 1, rr(5'b00010, 3, 4), 32'h3104, 32'hFFFF_FFFF, 32'h1);
        check("R6 ult", trap_req, 0);
        step("R6", 1, rr(5'b01000, 3, 4), 32'h3108, 32'h7FFF_FFFF, 32'h8000_0000);
        check("R6 sgt", trap_req, 1);
        for (int i = 0; i < 5; i++)
            step("R5", 1, rr(1 << i, 7, 8), 32'h3200 + i * 4, 32'h5, 32'h5);

        // R7: zero mask never traps
        step("R7", 1, rr(0, 0, 0), 32'h4000, 32'h0, 32'h0);
        check("R7 explicit", trap_req, 0);
        check("R2 bit0", insn_decoded, 1);
        step("R2", 1, rr(5'h1F, 1, 2) | 32'h1, 32'h4004, 32'h9, 32'h9);
        check("R2 reserved bit", insn_decoded, 1);

        // R3/R12: immediate form with negative constant
        step("R12", 1, ri(5'b00100, 2, 16'hFFFB), 32'h5000, 32'hFFFF_FFFB, 32'h0);
        check("R12 eq", trap_req, 1);
        step("R12", 1, ri(5'b10000, 2, 16'h8000), 32'h5004, 32'h0, 32'h0);
        check("R3 decoded", insn_decoded, 1);
        step("R12", 1, ri(5'b00010, 2, 16'hFFFF), 32'h5008, 32'h0, 32'h0);

        // R4: non-matching words
        step("R4", 1, (32'd31 << 26) | (5'h1F << 21) | (32'd5 << 1), 32'h6000, 32'h0, 32'h0);
        check("R4 xo", insn_decoded, 0);
        step("R4", 1, (32'd30 << 26) | (5'h1F << 21) | (32'd4 << 1), 32'h6004, 32'h0, 32'h0);
        step("R4", 1, 32'h0, 32'h6008, 32'h0, 32'h0);
        check("R10 hold after R4", trap_pc, 32'h5008);

        // Mixed patterns against the model
        for (int i = 0; i < 400; i++) begin
            bit [31:0] w;
            case ($urandom_range(0, 3))
                0: w = rr($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31));
                1: w = ri($urandom_range(0, 31), $urandom_range(0, 31), 16'($urandom));
                2: w = $urandom;
                default: w = 32'h7FE0_0008;
            endcase
            step("R5 mixed", $urandom_range(0, 3) != 0, w, $urandom,
                 ($urandom_range(0, 3) == 0) ? 32'h8000_0000 : $urandom,
                 ($urandom_range(0, 3) == 0) ? 32'h7FFF_FFFF : $urandom);
        end

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 0; insn_valid = 1; insn_word = 32'h7FE0_0008;
        @(negedge clk);
        check("R1 re-reset trap", trap_req, 0);
        check("R1 re-reset pc", trap_pc, 0);
        insn_valid = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule